// File: doc/BRIEF.md
# Four-Stack Minimal Instruction Set Core

This block is a small processor with no general registers. Its whole architectural state is four hardware stacks: a primary data stack (P1), the instruction-pointer stack (IP), and two further data stacks (R1, R2). The top entry of the IP stack is the byte address of the next instruction. The top of P1 also goes out to a display consumer. Instructions come from a 512-byte, byte-addressed memory. Each one is either one byte long (both operands from stacks) or three bytes long (the second operand is an 18-bit unsigned immediate).

Eight operations are supported: push, add, subtract, multiply, divide, two conditional skips and pop. A skip adds one byte to the top of IP on top of the normal advance. A jump or call is a push onto the IP stack, and a return is a pop of it. A rising edge on the single-step input runs exactly one instruction. Holding the run input high runs one instruction per clock. A byte-wide load port fills the memory before execution.

Top module: `quadstack_core`

## Requirements
- R1: After reset, P1, R1 and R2 are empty and the IP stack holds one entry of value 0. retire_o is low. An empty stack reads as 0 wherever it is used as an operand or shown on a port.
- R2: Instruction byte 0 has this layout: bits [2:0] opcode, bit 3 immediate flag, bits [5:4] first-operand stack (00 P1, 01 IP, 10 R1, 11 R2). With the flag set, the instruction is 3 bytes long and the second operand is the zero-extended 18-bit value formed as {byte2, byte1, byte0[7:6]}, with byte1 at address+1 and byte2 at address+2. With the flag clear, the instruction is 1 byte long.
- R3: With the flag clear, bits [7:6] pick the second-operand stack using the same code. When that code equals the first selector, the second operand is the entry just below the top of that stack.
- R4: Opcode 0 pushes the second operand onto the first stack. Opcodes 1, 2, 3 and 4 push A+B, A-B, A*B (low 32 bits) and A/B (signed, truncated toward zero) onto the first stack. A is left in place.
- R5: Division by zero pushes 0. Dividing the most negative 32-bit value by -1 pushes the most negative value.
- R6: Opcode 5 skips one byte when A differs from B. Opcode 6 skips one byte when A is less than or equal to B, comparing as signed.
- R7: Opcode 7 pops the first stack and ignores the second operand. A pop of an empty stack leaves it empty.
- R8: Each stack holds 16 entries. A push onto a full stack discards the oldest entry and the depth stays at 16.
- R9: After an instruction, the top of IP becomes (old top + length + skip) modulo 512. The exception is an instruction that pushed onto or popped the IP stack; in that case no advance is applied.
- R10: A 0-to-1 change of step_i runs one instruction, and holding step_i high runs no more. While run_i is high, one instruction runs per clock. retire_o is high in the cycle after each executed instruction. With neither input active, stack state does not change.
- R11: A load pulse writes load_data_i to memory at load_addr_i. Fetch addresses wrap modulo 512, so an immediate instruction at 511 takes its operand bytes from addresses 0 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_i | input | 1 | Single-step request, acts on its rising edge |
| run_i | input | 1 | Continuous execution while high |
| load_en_i | input | 1 | Memory byte write enable |
| load_addr_i | input | 9 | Memory byte write address |
| load_data_i | input | 8 | Memory byte write data |
| p1_top_o | output | 32 | Top of P1 (display feed) |
| ip_top_o | output | 32 | Top of IP |
| r1_top_o | output | 32 | Top of R1 |
| r2_top_o | output | 32 | Top of R2 |
| depth_o | output | 20 | Stack depths, 5 bits each: P1 [4:0], IP [9:5], R1 [14:10], R2 [19:15] |
| retire_o | output | 1 | One instruction was executed in the previous cycle |

## Verification
The stack tops and depths are on the ports, so a corrupted push, pop or drop-oldest shows up in the clock right after the faulty instruction. A wrong entry below the top stays hidden until a later pop or a same-stack operand brings it to the surface, so the programs pop and reuse second entries on purpose. A fault in fetch, decode or skip logic appears as a wrong IP top one clock later, and then as wrong data on every instruction that follows.

// File: rtl/qs_pkg.sv
package qs_pkg;
  localparam int DATA_W = 32;
  localparam int IMM_W  = 18;

  typedef enum logic [1:0] {SEL_P1 = 2'd0, SEL_IP = 2'd1, SEL_R1 = 2'd2, SEL_R2 = 2'd3} stk_sel_e;
  typedef enum logic [1:0] {SC_NONE, SC_PUSH, SC_POP, SC_SET} stk_cmd_e;

  typedef struct packed {
    logic [2:0]       op;
    logic             imm;
    logic [1:0]       s1;
    logic [1:0]       s2;
    logic [IMM_W-1:0] imm_val;
    logic [1:0]       len;
  } instr_t;

  function automatic instr_t qs_decode(input logic [7:0] b0, input logic [7:0] b1,
                                       input logic [7:0] b2);
    instr_t d;
    d.op      = b0[2:0];
    d.imm     = b0[3];
    d.s1      = b0[5:4];
    d.s2      = b0[7:6];
    d.imm_val = {b2, b1, b0[7:6]};
    d.len     = b0[3] ? 2'd3 : 2'd1;
    return d;
  endfunction

  function automatic logic signed [DATA_W-1:0] qs_div(input logic signed [DATA_W-1:0] a,
                                                      input logic signed [DATA_W-1:0] b);
    logic signed [DATA_W-1:0] minv;
    minv = {1'b1, {(DATA_W-1){1'b0}}};
    if (b == '0) return '0;
    if (a == minv && b == -1) return minv;
    return a / b;
  endfunction

  function automatic logic signed [DATA_W-1:0] qs_alu(input logic [2:0] op,
                                                      input logic signed [DATA_W-1:0] a,
                                                      input logic signed [DATA_W-1:0] b);
    case (op)
      3'd1:    return a + b;
      3'd2:    return a - b;
      3'd3:    return a * b;
      3'd4:    return qs_div(a, b);
      default: return b;
    endcase
  endfunction

  function automatic logic qs_skip(input logic [2:0] op, input logic signed [DATA_W-1:0] a,
                                   input logic signed [DATA_W-1:0] b);
    if (op == 3'd5) return a != b;
    if (op == 3'd6) return a <= b;
    return 1'b0;
  endfunction
endpackage

// File: rtl/qs_stack.sv
module qs_stack #(
  parameter int DEPTH     = 16,
  parameter int W         = 32,
  parameter int RST_DEPTH = 0
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  qs_pkg::stk_cmd_e             cmd,
  input  logic [W-1:0]                 din,
  output logic [W-1:0]                 top,
  output logic [W-1:0]                 nxt,
  output logic [$clog2(DEPTH+1)-1:0]   depth
);
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [W-1:0]  ent [DEPTH];
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) ent[i] <= '0;
      cnt <= CW'(RST_DEPTH);
    end else begin
      case (cmd)
        qs_pkg::SC_PUSH: begin
          ent[0] <= din;
          for (int i = 1; i < DEPTH; i++) ent[i] <= ent[i-1];
          if (cnt != FULL) cnt <= cnt + 1'b1;
        end
        qs_pkg::SC_POP: if (cnt != '0) begin
          for (int i = 0; i < DEPTH-1; i++) ent[i] <= ent[i+1];
          ent[DEPTH-1] <= '0;
          cnt <= cnt - 1'b1;
        end
        qs_pkg::SC_SET: begin
          ent[0] <= din;
          if (cnt == '0) cnt <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign top   = (cnt != '0)       ? ent[0] : '0;
  assign nxt   = (cnt > CW'(1))    ? ent[1] : '0;
  assign depth = cnt;

  assert_depth_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= FULL);
  assert_full_push_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == qs_pkg::SC_PUSH && depth == FULL) |=> (depth == FULL && top == $past(din)));
  assert_empty_pop_stays_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == qs_pkg::SC_POP && depth == '0) |=> depth == '0);
endmodule

// File: rtl/qs_mem.sv
module qs_mem #(
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_b0,
  output logic [7:0]    rd_b1,
  output logic [7:0]    rd_b2
);
  localparam int BYTES = 1 << AW;

  logic [7:0]    bytes_q [BYTES];
  logic [AW-1:0] a1, a2;

  always_ff @(posedge clk) begin
    if (wr_en) bytes_q[wr_addr] <= wr_data;
  end

  assign a1    = rd_addr + AW'(1);
  assign a2    = rd_addr + AW'(2);
  assign rd_b0 = bytes_q[rd_addr];
  assign rd_b1 = bytes_q[a1];
  assign rd_b2 = bytes_q[a2];
endmodule

// File: rtl/quadstack_core.sv
module quadstack_core #(
  parameter int DEPTH = 16,
  parameter int AW    = 9
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             step_i,
  input  logic                             run_i,
  input  logic                             load_en_i,
  input  logic [AW-1:0]                    load_addr_i,
  input  logic [7:0]                       load_data_i,
  output logic [qs_pkg::DATA_W-1:0]        p1_top_o,
  output logic [qs_pkg::DATA_W-1:0]        ip_top_o,
  output logic [qs_pkg::DATA_W-1:0]        r1_top_o,
  output logic [qs_pkg::DATA_W-1:0]        r2_top_o,
  output logic [4*$clog2(DEPTH+1)-1:0]     depth_o,
  output logic                             retire_o
);
  import qs_pkg::*;
  localparam int W      = DATA_W;
  localparam int CW     = $clog2(DEPTH+1);
  localparam int NSTK   = 4;

  logic [W-1:0]  top_w [NSTK];
  logic [W-1:0]  nxt_w [NSTK];
  logic [W-1:0]  din_w [NSTK];
  stk_cmd_e      cmd_w [NSTK];
  logic [CW-1:0] dep_w [NSTK];

  logic          step_q, retire_q;
  logic          exec_w, ip_wr_w, skip_w;
  logic [7:0]    b0, b1, b2;
  instr_t        ins;
  logic [W-1:0]  opa_w, opb_w, alu_w, new_ip_w;
  logic [2:0]    adv_w;
  logic [AW-1:0] nip_w;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_q   <= 1'b0;
      retire_q <= 1'b0;
    end else begin
      step_q   <= step_i;
      retire_q <= exec_w;
    end
  end

  assign exec_w = run_i | (step_i & ~step_q);

  qs_mem #(.AW(AW)) u_mem (
    .clk(clk), .wr_en(load_en_i), .wr_addr(load_addr_i), .wr_data(load_data_i),
    .rd_addr(top_w[SEL_IP][AW-1:0]), .rd_b0(b0), .rd_b1(b1), .rd_b2(b2)
  );

  assign ins   = qs_decode(b0, b1, b2);
  assign opa_w = top_w[ins.s1];
  assign opb_w = ins.imm ? W'(ins.imm_val)
               : (ins.s2 == ins.s1) ? nxt_w[ins.s1] : top_w[ins.s2];
  assign alu_w  = qs_alu(ins.op, opa_w, opb_w);
  assign skip_w = qs_skip(ins.op, opa_w, opb_w);
  assign ip_wr_w = (ins.s1 == SEL_IP) && (ins.op != 3'd5) && (ins.op != 3'd6);
  assign adv_w   = {1'b0, ins.len} + {2'b0, skip_w};
  assign nip_w   = top_w[SEL_IP][AW-1:0] + AW'(adv_w);
  assign new_ip_w = W'(nip_w);

  for (genvar g = 0; g < NSTK; g++) begin : g_stk
    always_comb begin
      cmd_w[g] = SC_NONE;
      din_w[g] = alu_w;
      if (exec_w) begin
        if (ins.s1 == 2'(g)) begin
          if (ins.op == 3'd7)     cmd_w[g] = SC_POP;
          else if (ins.op < 3'd5) cmd_w[g] = SC_PUSH;
        end
        if (g == int'(SEL_IP) && !ip_wr_w) begin
          cmd_w[g] = SC_SET;
          din_w[g] = new_ip_w;
        end
      end
    end

    qs_stack #(.DEPTH(DEPTH), .W(W), .RST_DEPTH(g == int'(SEL_IP) ? 1 : 0)) u_stk (
      .clk(clk), .rst_n(rst_n), .cmd(cmd_w[g]), .din(din_w[g]),
      .top(top_w[g]), .nxt(nxt_w[g]), .depth(dep_w[g])
    );
    assign depth_o[g*CW +: CW] = dep_w[g];
  end

  assign p1_top_o = top_w[SEL_P1];
  assign ip_top_o = top_w[SEL_IP];
  assign r1_top_o = top_w[SEL_R1];
  assign r2_top_o = top_w[SEL_R2];
  assign retire_o = retire_q;

  assert_ip_advance_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_w && !ip_wr_w) |=>
      ((ip_top_o[AW-1:0] - $past(ip_top_o[AW-1:0])) == AW'($past(adv_w))));
  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_w |=> ($stable(ip_top_o) && $stable(p1_top_o) && $stable(depth_o)));
  assert_step_once_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && step_i && $past(step_i)) |-> !exec_w);
  assert_retire_marks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_w && !ip_wr_w) |=> retire_o);
  assert_pop_ignores_b_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_w && ins.op == 3'd7 && ins.s1 != SEL_P1 && ins.s2 == SEL_P1) |=> $stable(p1_top_o));
endmodule

// File: tb/quadstack_core_bench.sv
`timescale 1ns/1ps
module quadstack_core_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        step_i = 1'b0, run_i = 1'b0, load_en_i = 1'b0;
  logic [8:0]  load_addr_i = '0;
  logic [7:0]  load_data_i = '0;
  logic [31:0] p1_top_o, ip_top_o, r1_top_o, r2_top_o;
  logic [19:0] depth_o;
  logic        retire_o;

  always #5 clk = ~clk;

  quadstack_core u_quadstack_core (
    .clk(clk), .rst_n(rst_n), .step_i(step_i), .run_i(run_i), .load_en_i(load_en_i),
    .load_addr_i(load_addr_i), .load_data_i(load_data_i), .p1_top_o(p1_top_o),
    .ip_top_o(ip_top_o), .r1_top_o(r1_top_o), .r2_top_o(r2_top_o),
    .depth_o(depth_o), .retire_o(retire_o)
  );

  int  vectors = 0, miscompares = 0, retires = 0, pc = 0;
  bit  done = 1'b0;
  bit  prev_step = 1'b0, exp_retire = 1'b0;
  int  stk [4][$];
  logic [7:0] mem_m [512];

  function automatic int mtop(int s);
    return stk[s].size() > 0 ? stk[s][0] : 0;
  endfunction
  function automatic int msec(int s);
    return stk[s].size() > 1 ? stk[s][1] : 0;
  endfunction
  function automatic void mpush(int s, int v);
    stk[s].push_front(v);
    if (stk[s].size() > 16) void'(stk[s].pop_back());
  endfunction

  function automatic void model_reset();
    for (int s = 0; s < 4; s++) stk[s].delete();
    stk[1].push_front(0);
    prev_step = 1'b0;
    exp_retire = 1'b0;
  endfunction

  function automatic void model_exec();
    int ip, a, b, r, len, skip, op, s1, s2;
    logic [7:0] c0, c1, c2;
    ip = mtop(1) & 511;
    c0 = mem_m[ip]; c1 = mem_m[(ip + 1) % 512]; c2 = mem_m[(ip + 2) % 512];
    op = c0[2:0]; s1 = c0[5:4]; s2 = c0[7:6];
    len = c0[3] ? 3 : 1;
    a = mtop(s1);
    if (c0[3]) b = c0[7:6] + c1 * 4 + c2 * 1024;
    else if (s2 == s1) b = msec(s1);
    else b = mtop(s2);
    skip = 0;
    r = 0;
    case (op)
      0: r = b;
      1: r = a + b;
      2: r = a - b;
      3: r = a * b;
      4: r = (b == 0) ? 0 : (a == 32'sh80000000 && b == -1) ? a : a / b;
      5: skip = (a != b) ? 1 : 0;
      6: skip = (a <= b) ? 1 : 0;
      default: ;
    endcase
    if (op < 5) mpush(s1, r);
    else if (op == 7 && stk[s1].size() > 0) void'(stk[s1].pop_front());
    if (!(s1 == 1 && op != 5 && op != 6)) begin
      if (stk[1].size() == 0) stk[1].push_front((ip + len + skip) % 512);
      else stk[1][0] = (ip + len + skip) % 512;
    end
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    bit ex;
    ex = run_i | (step_i & ~prev_step);
    prev_step = step_i;
    if (ex) model_exec();
    if (load_en_i) mem_m[load_addr_i] = load_data_i;
    exp_retire = ex;
    @(posedge clk);
    @(negedge clk);
    chk("R4", "p1_top", int'(p1_top_o), mtop(0));
    chk("R9", "ip_top", int'(ip_top_o), mtop(1));
    chk("R4", "r1_top", int'(r1_top_o), mtop(2));
    chk("R4", "r2_top", int'(r2_top_o), mtop(3));
    chk("R7", "depth",  int'(depth_o),
        stk[0].size() | (stk[1].size() << 5) | (stk[2].size() << 10) | (stk[3].size() << 15));
    chk("R10", "retire", int'(retire_o), int'(exp_retire));
    if (retire_o) retires++;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; step_i = 1'b0; run_i = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    model_reset();
  endtask

  task automatic load(int a, logic [7:0] d);
    load_en_i = 1'b1; load_addr_i = 9'(a); load_data_i = d;
    tick();
    load_en_i = 1'b0;
  endtask

  task automatic emit_s(int op, int s1, int s2);
    load(pc, {2'(s2), 2'(s1), 1'b0, 3'(op)});
    pc = pc + 1;
  endtask

  task automatic emit_i(int op, int s1, int imm);
    logic [17:0] v;
    v = 18'(imm);
    load(pc, {v[1:0], 2'(s1), 1'b1, 3'(op)});
    load(pc + 1, v[9:2]);
    load(pc + 2, v[17:10]);
    pc = pc + 3;
  endtask

  task automatic step1();
    step_i = 1'b1; tick();
    step_i = 1'b0; tick();
  endtask

  initial begin
    #2000000;
    if (!done) begin
      miscompares++;
      vectors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    int ip_hold, r0;
    do_reset();
    tick();
    chk("R1", "depth after reset", int'(depth_o), 32);
    chk("R1", "ip after reset", int'(ip_top_o), 0);
    chk("R1", "p1 empty reads 0", int'(p1_top_o), 0);
    for (int a = 0; a < 512; a++) load(a, 8'h00);

    // Program A: stack arithmetic, skips, pops, call loop
    pc = 0;
    emit_i(0, 0, 7); emit_i(0, 0, 5); emit_s(1, 0, 0);
    emit_i(0, 2, 3); emit_s(3, 2, 0); emit_s(2, 3, 2);
    emit_s(4, 3, 2); emit_s(4, 2, 3); emit_i(0, 3, 0);
    emit_s(4, 0, 3); emit_s(5, 0, 0); emit_s(7, 0, 0);
    emit_s(6, 2, 3); emit_s(7, 0, 0); emit_s(6, 0, 2);
    emit_s(7, 3, 0); emit_s(7, 3, 0); emit_s(7, 3, 0); emit_s(7, 3, 0);
    emit_i(0, 1, 40);
    pc = 40;
    emit_i(0, 0, 18'h3FFFF); emit_s(7, 1, 0);

    step1(); step1();
    chk("R2", "p1 top after two immediates", int'(p1_top_o), 5);
    chk("R2", "p1 depth", int'(depth_o[4:0]), 2);
    step1();
    chk("R3", "add with same selector", int'(p1_top_o), 12);
    step1(); step1();
    chk("R3", "mul R1 by P1", int'(r1_top_o), 36);
    step1();
    chk("R3", "sub from empty R2", int'(r2_top_o), -36);
    step1();
    chk("R4", "signed div", int'(r2_top_o), -1);
    step1();
    chk("R4", "div negative divisor", int'(r1_top_o), -36);
    step1(); step1();
    chk("R5", "divide by zero", int'(p1_top_o), 0);
    step1();
    chk("R6", "ne skip taken", int'(ip_top_o), 20);
    step1();
    chk("R6", "le skip taken", int'(ip_top_o), 22);
    step1();
    chk("R6", "le skip not taken", int'(ip_top_o), 23);
    step1(); step1(); step1(); step1();
    chk("R7", "pop past empty", int'(depth_o[19:15]), 0);
    r0 = retires;
    step_i = 1'b1; tick(); tick(); tick();
    step_i = 1'b0; tick();
    chk("R10", "held step runs once", retires - r0, 1);
    chk("R9", "push onto IP jumps", int'(ip_top_o), 40);
    chk("R9", "IP depth after call", int'(depth_o[9:5]), 2);
    run_i = 1'b1;
    for (int i = 0; i < 60; i++) tick();
    run_i = 1'b0; tick();
    chk("R8", "P1 saturates at 16", int'(depth_o[4:0]), 16);
    chk("R2", "full 18-bit immediate", int'(p1_top_o), 32'h3FFFF);
    ip_hold = int'(ip_top_o);
    tick(); tick(); tick();
    chk("R10", "idle holds ip", int'(ip_top_o), ip_hold);

    // Program B: overflow corners
    do_reset();
    pc = 0;
    emit_i(0, 2, 131072); emit_i(0, 3, 16384); emit_s(3, 2, 3);
    emit_i(0, 3, 1); emit_s(2, 0, 3); emit_s(4, 2, 0);
    emit_s(6, 2, 0); emit_s(7, 2, 0);
    step1(); step1(); step1();
    chk("R4", "mul low 32 bits", int'(r1_top_o), 32'h80000000);
    step1(); step1();
    chk("R4", "sub from empty P1", int'(p1_top_o), -1);
    step1();
    chk("R5", "min by minus one", int'(r1_top_o), 32'h80000000);
    step1();
    chk("R6", "signed le skip", int'(ip_top_o), 14);

    // Program C: fetch wrap at the top of memory
    do_reset();
    pc = 0;
    emit_i(0, 1, 511);
    load(511, 8'h28);
    step1();
    chk("R9", "jump to 511", int'(ip_top_o), 511);
    step1();
    chk("R11", "wrapped immediate", int'(r1_top_o), 130912);
    chk("R11", "ip wraps", int'(ip_top_o), 2);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule